// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

The sequencer drives the winding-enable lines of a stepper motor. Each accepted step moves a state index one place through the phase pattern of the selected mode, in the direction the direction input gives. The winding outputs are decoded from that index. Four patterns are available:

- a three-winding variable-reluctance pattern;
- single-coil wave drive;
- two-coil full step, which gives about 1.4 times the torque for twice the winding power;
- eight-state half step.

A signed position counter tracks the net number of accepted steps.

Step requests come from two sources. One is an external single-cycle pulse. The other is an internal rate generator that accumulates a programmed steps-per-second value against the clock frequency. A target speed in RPM converts to that value as RPM × steps-per-revolution / 60. For example, a 30-degree variable-reluctance motor takes 12 steps per revolution, which is four passes through its three-state pattern.

A mode change is applied only in a cycle with no step. The index is then folded into the range of the new pattern, so an illegal winding combination never appears on the outputs.

Top module: `stepper_phase_seq`

## Requirements
- R1: While `rst_n` is low, `winding` is 0 and `position` is 0. After reset the index is 0 and the latched mode is 0.
- R2: In mode 0 (variable reluctance), bits 0, 1 and 2 of `winding` are W1, W2 and W3, and bit 3 is 0. Forward steps give 001, 010, 100 and then repeat.
- R3: In mode 1 (wave drive), the bit order is bit0 = W1a, bit1 = W2a, bit2 = W1b, bit3 = W2b. Index 0 to 3 gives 0001, 0010, 0100, 1000.
- R4: In mode 2 (two-coil full step), index 0 to 3 gives 1001, 0011, 0110, 1100.
- R5: In mode 3 (half step), index 0 to 7 gives 0001, 0011, 0010, 0110, 0100, 1100, 1000, 1001. One winding and two windings alternate.
- R6: An accepted step with `dir` = 1 increments the index, and with `dir` = 0 decrements it. The index wraps modulo the pattern length (3, 4, 4 or 8). The new pattern appears after the clock edge that takes the step.
- R7: Each accepted step adds 1 to `position` when `dir` = 1 and subtracts 1 when `dir` = 0. The counter is two's complement and wraps.
- R8: A `mode` value that differs from the latched mode is taken at the first clock edge with no accepted step. At that edge the index becomes the old index modulo the new length. A step in the same cycle uses the old mode.
- R9: While `enable` is low, `winding` is 0 and step requests have no effect on the index or `position`.
- R10: With `auto_en` high, `sps` is added to an accumulator every cycle. A step is made, and `CLK_HZ` is subtracted, on each cycle where the sum reaches `CLK_HZ`. This gives `sps` steps per second. The accumulator clears while `auto_en` is low. `sps` must stay below `CLK_HZ`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Drive enable; low forces all windings off |
| step_req | input | 1 | Single-cycle step request |
| dir | input | 1 | 1 = forward (increment), 0 = reverse |
| mode | input | 2 | 0 VR, 1 wave, 2 two-coil, 3 half step |
| auto_en | input | 1 | Enable the internal rate generator |
| sps | input | RATE_W | Steps per second for the rate generator |
| winding | output | 4 | Winding enables |
| position | output | POS_W | Signed step position |

## Verification
The bench walks each pattern forward through a full wrap and then reverses it. A reversed step that returns the wrong state shows that the index decrement is wrong, even where a forward cycle alone looks correct. Mode changes are made from indices that are out of range for the new pattern: half-step 6 to VR, and half-step 5 to wave. These show whether the modulo remap is done at all. A step issued in the same cycle as a mode change shows whether the step takes priority. Disabled step requests and the rate generator at a known `sps`/`CLK_HZ` ratio, and at zero, are checked through `winding` and `position`.

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq #(
  parameter int CLK_HZ = 50_000_000,
  parameter int RATE_W = 26,
  parameter int POS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    step_req,
  input  logic                    dir,
  input  logic [1:0]              mode,
  input  logic                    auto_en,
  input  logic [RATE_W-1:0]       sps,
  output logic [3:0]              winding,
  output logic signed [POS_W-1:0] position
);
  localparam int ACC_W = RATE_W + 1;
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(CLK_HZ);

  logic [1:0]       cur_mode;
  logic [2:0]       idx;
  logic [2:0]       last;
  logic [3:0]       pat;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_sum;
  logic             tick;
  logic             step_fire;

  assign acc_sum   = acc + ACC_W'(sps);
  assign tick      = auto_en && (acc_sum >= LIMIT);
  assign step_fire = enable && (step_req || tick);
  assign last      = (cur_mode == 2'd0) ? 3'd2 : (cur_mode == 2'd3) ? 3'd7 : 3'd3;

  function automatic logic [2:0] fold(input logic [2:0] i, input logic [1:0] m);
    case (m)
      2'd0:    fold = i % 3'd3;
      2'd3:    fold = i;
      default: fold = {1'b0, i[1:0]};
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else if (!auto_en) acc <= '0;
    else if (tick) acc <= acc_sum - LIMIT;
    else acc <= acc_sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      cur_mode <= 2'd0;
      position <= '0;
    end else if (step_fire) begin
      if (dir) idx <= (idx == last) ? 3'd0 : idx + 3'd1;
      else     idx <= (idx == 3'd0) ? last : idx - 3'd1;
      position <= dir ? position + POS_W'(1) : position - POS_W'(1);
    end else if (mode != cur_mode) begin
      cur_mode <= mode;
      idx      <= fold(idx, mode);
    end
  end

  always_comb begin
    pat = 4'b0000;
    case (cur_mode)
      2'd0: pat = {1'b0, 3'b001 << idx[1:0]};
      2'd1: pat = 4'b0001 << idx[1:0];
      2'd2:
        case (idx[1:0])
          2'd0: pat = 4'b1001;
          2'd1: pat = 4'b0011;
          2'd2: pat = 4'b0110;
          default: pat = 4'b1100;
        endcase
      default:
        case (idx)
          3'd0: pat = 4'b0001;
          3'd1: pat = 4'b0011;
          3'd2: pat = 4'b0010;
          3'd3: pat = 4'b0110;
          3'd4: pat = 4'b0100;
          3'd5: pat = 4'b1100;
          3'd6: pat = 4'b1000;
          default: pat = 4'b1001;
        endcase
    endcase
  end

  assign winding = (rst_n && enable) ? pat : 4'b0000;

  assert_vr_one_hot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cur_mode == 2'd0) |-> ($onehot(winding[2:0]) && !winding[3]));
  assert_wave_one_hot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cur_mode == 2'd1) |-> $onehot(winding));
  assert_two_coil_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cur_mode == 2'd2) |-> ($countones(winding) == 2));
  assert_half_one_or_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cur_mode == 2'd3) |-> ($countones(winding) inside {1, 2}));
  assert_index_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= last);
  assert_position_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> position == ($past(dir) ? $past(position) + POS_W'(1)
                                          : $past(position) - POS_W'(1)));
  assert_position_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_fire |=> $stable(position));
  assert_mode_held_on_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> $stable(cur_mode));
  assert_disabled_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> winding == 4'b0000);
endmodule

// File: tb/stepper_phase_seq_bench.sv
module stepper_phase_seq_bench;
  localparam int POS_W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic step_req = 1'b0;
  logic dir = 1'b1;
  logic [1:0] mode = 2'd0;
  logic auto_en = 1'b0;
  logic [7:0] sps = 8'd0;
  logic [3:0] winding;
  logic signed [POS_W-1:0] position;

  int compared = 0;
  int mismatched = 0;
  int exp_pos = 0;

  always #2.5 clk = ~clk;

  stepper_phase_seq #(.CLK_HZ(100), .RATE_W(8), .POS_W(POS_W)) u_stepper_phase_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step_req(step_req), .dir(dir),
    .mode(mode), .auto_en(auto_en), .sps(sps), .winding(winding), .position(position));

  // {mode, dir, expected winding after the step}
  localparam logic [6:0] VEC [0:21] = '{
    7'b00_1_0010, 7'b00_1_0100, 7'b00_1_0001, 7'b00_0_0100, 7'b00_0_0010,
    7'b01_1_0100, 7'b01_1_1000, 7'b01_1_0001, 7'b01_0_1000,
    7'b10_1_1001, 7'b10_1_0011, 7'b10_1_0110, 7'b10_1_1100, 7'b10_0_0110,
    7'b11_1_0110, 7'b11_1_0100, 7'b11_1_1100, 7'b11_1_1000, 7'b11_1_1001,
    7'b11_1_0001, 7'b11_0_1001, 7'b11_0_1000};

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_step(input logic d);
    @(negedge clk);
    dir = d;
    step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
    if (enable) exp_pos += d ? 1 : -1;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 winding in reset", winding, 0);
    check("R1 position in reset", position, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1/R2 index 0 after reset", winding, 4'b0001);

    // R2 R3 R4 R5 R6 R7: vector walk
    for (int i = 0; i < 22; i++) begin
      if (VEC[i][6:5] != mode) set_mode(VEC[i][6:5]);
      do_step(VEC[i][4]);
      check($sformatf("R2-5/R6 vector %0d winding", i), winding, VEC[i][3:0]);
      check($sformatf("R7 vector %0d position", i), position, exp_pos);
    end

    // R8: half index 6 -> VR folds to 0
    set_mode(2'd0);
    check("R8 half6 to VR", winding, 4'b0001);
    set_mode(2'd3);
    check("R8 VR0 to half", winding, 4'b0001);
    do_step(1'b0); do_step(1'b0); do_step(1'b0);
    check("R5 half index 5", winding, 4'b1100);
    set_mode(2'd1);
    check("R8 half5 to wave", winding, 4'b0010);

    // R8: step and mode change in the same cycle
    @(negedge clk);
    mode = 2'd0; dir = 1'b1; step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
    exp_pos += 1;
    check("R8 step uses old mode", winding, 4'b0100);
    @(negedge clk);
    check("R8 mode taken next idle cycle", winding, 4'b0100);
    check("R7 position after combined", position, exp_pos);

    // R9: disable
    @(negedge clk);
    enable = 1'b0;
    #1 check("R9 winding off when disabled", winding, 0);
    do_step(1'b1);
    do_step(1'b0);
    check("R9 winding still off", winding, 0);
    @(negedge clk);
    enable = 1'b1;
    #1 check("R9 index unchanged", winding, 4'b0100);
    check("R9 position unchanged", position, exp_pos);

    // R10: rate generator, 25 of 100 -> one step per 4 cycles
    @(negedge clk);
    dir = 1'b1; sps = 8'd25; auto_en = 1'b1;
    repeat (40) @(negedge clk);
    auto_en = 1'b0;
    exp_pos += 10;
    check("R10 auto steps in 40 cycles", position, exp_pos);
    check("R10 VR index after 10 steps", winding, 4'b0001);
    @(negedge clk);
    sps = 8'd0; auto_en = 1'b1;
    repeat (20) @(negedge clk);
    auto_en = 1'b0;
    check("R10 zero rate makes no step", position, exp_pos);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 winding after reset", winding, 0);
    check("R1 position after reset", position, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule